// File: doc/BRIEF.md
# Sixteen-Bit Compare and Gated Interval Timer

This peripheral timer holds a 16-bit up-counter, a 16-bit reload/compare value and a control byte, all written through a narrow byte-wide write port. It runs in one of two modes. In compare mode it advances on every prescaled tick and wraps from FFFFh to 0000h. Each time the count lands on the compare value it pulses the interrupt and, if output toggling is enabled, inverts the timer output pin. The count is never cleared by a match.

In gated mode the counter advances only while a synchronised external input sits at its active level. The active level is software selectable. An interrupt is raised when the count, having reached the reload value, is restarted at 0001h. An interrupt is also raised when the input leaves its active level. Software programs a starting count, a reload value, a prescale exponent, a mode and an initial output level while the timer is stopped, and then sets the enable bit.

Top module: `gtm_timer`

## Requirements
- R1: After reset, `tmr_out` is 0, `irq` is 0 and the timer is disabled.
- R2: In compare mode (control bit 1 = 0), with start count S and compare value C, the first `irq` pulse comes (C−S) mod 65536 prescaled ticks after enabling. The count carries on from C after a match. A compare value rewritten after a match is reached after only the extra ticks needed.
- R3: In compare mode the count wraps from FFFFh to 0000h and keeps counting.
- R4: With output toggling enabled (control bit 4 = 1), `tmr_out` inverts on each compare match, in the same cycle as the `irq` pulse. With control bit 4 = 0, `tmr_out` does not change on a match.
- R5: A control write made while the timer is disabled loads `tmr_out` from control bit 3. While the timer is disabled and no control write occurs, `tmr_out` holds its level.
- R6: The prescaler divides the clock by 2^E, where E is control bits 7:5 (0 to 7, a ratio of 1 to 128). The prescaler is cleared while the timer is disabled.
- R7: In gated mode (control bit 1 = 1), the count advances only while the synchronised input equals control bit 2 (1 = active high, 0 = active low). The tick on which the count equals the reload value sets the count to 0001h and pulses `irq`.
- R8: In gated mode, when the input leaves its active level, `irq` pulses 3 clock edges after the change. This latency comes from two synchroniser flops plus the registered output.
- R9: Register addresses are: 0 control (bit 0 = enable), 1 count high byte, 2 count low byte, 3 reload high byte, 4 reload low byte. A count byte written while disabled takes effect at once. A count byte written while enabled replaces that byte on the next prescaled tick, and no increment or match happens on that tick.
- R10: `irq` is a one-cycle pulse per event, and it never asserts while the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| tmr_in | input | 1 | External gate input, asynchronous |
| tmr_out | output | 1 | Timer output level |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench times the interval from enabling to each interrupt across prescale ratios up to 128 and across a start count that forces wrap-around. A design that reset the count on a match, or that failed to wrap, would show an interval far longer than expected. It restarts the prescaler mid-period to catch a divider that keeps a stale phase and so fires early. It pauses and resumes the gate in both polarities to expose a counter that keeps running while the gate is closed, or a deassert interrupt that arrives at the wrong edge. It also writes count bytes while the timer runs and expects the load exactly one tick later.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
    localparam int GTM_DATA_W = 8;
    localparam int GTM_CNT_W  = 2 * GTM_DATA_W;
    localparam int GTM_ADDR_W = 3;
    localparam int GTM_EXP_W  = 3;

    // control byte bit positions
    localparam int CB_EN   = 0;
    localparam int CB_MODE = 1;
    localparam int CB_POL  = 2;
    localparam int CB_INIT = 3;
    localparam int CB_OEN  = 4;
    localparam int CB_EXP  = 5;

    typedef enum logic [GTM_ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_CNTH = 3'd1,
        A_CNTL = 3'd2,
        A_RLDH = 3'd3,
        A_RLDL = 3'd4
    } gtm_addr_e;

    typedef enum logic {
        MODE_CMP  = 1'b0,
        MODE_GATE = 1'b1
    } gtm_mode_e;

    typedef struct packed {
        logic [GTM_CNT_W-1:0]  cnt;
        logic [GTM_CNT_W-1:0]  rld;
        logic                  en;
        gtm_mode_e             mode;
        logic                  pol;
        logic                  init;
        logic                  oen;
        logic [GTM_EXP_W-1:0]  exp;
        logic                  out;
        logic                  irq;
        logic                  ph_v;
        logic                  pl_v;
        logic [GTM_DATA_W-1:0] ph;
        logic [GTM_DATA_W-1:0] pl;
    } gtm_state_t;
endpackage

// File: rtl/gtm_prescale.sv
module gtm_prescale #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [EXP_W-1:0] exp,
    output logic             tick
);
    localparam int CW = (1 << EXP_W) - 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    // terminal count has the low 'exp' bits set
    always_comb begin
        for (int i = 0; i < CW; i++) begin
            lim[i] = (i < int'(exp));
        end
    end

    always_comb begin
        tick  = run && (cnt_q == lim);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = tick ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gtm_gate_sync.sv
module gtm_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic act,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              act_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign act  = (sync_q[STAGES-1] == pol);
    assign fall = act_q && !act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
    end
endmodule

// File: rtl/gtm_timer.sv
module gtm_timer
    import gtm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [GTM_ADDR_W-1:0] wr_addr,
    input  logic [GTM_DATA_W-1:0] wr_data,
    input  logic                  tmr_in,
    output logic                  tmr_out,
    output logic                  irq
);
    localparam int HI = GTM_CNT_W - 1;
    localparam int LO = GTM_DATA_W;

    gtm_state_t st_d, st_q;
    logic tick_w;
    logic gate_act_w;
    logic gate_fall_w;
    logic run_w;
    logic pend_w;

    assign run_w  = st_q.en && (st_q.mode == MODE_CMP || gate_act_w);
    assign pend_w = st_q.ph_v || st_q.pl_v;

    gtm_prescale #(.EXP_W(GTM_EXP_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!st_q.en),
        .run  (run_w),
        .exp  (st_q.exp),
        .tick (tick_w)
    );

    gtm_gate_sync #(.STAGES(SYNC_STAGES)) u_gate (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (tmr_in),
        .pol  (st_q.pol),
        .act  (gate_act_w),
        .fall (gate_fall_w)
    );

    always_comb begin
        logic [GTM_CNT_W-1:0] nxt;
        st_d     = st_q;
        st_d.irq = 1'b0;
        nxt      = st_q.cnt + 1'b1;

        if (!st_q.en) begin
            st_d.ph_v = 1'b0;
            st_d.pl_v = 1'b0;
        end

        // counting on a prescaled tick
        if (st_q.en && tick_w) begin
            if (pend_w) begin
                st_d.cnt  = {st_q.ph_v ? st_q.ph : st_q.cnt[HI:LO],
                             st_q.pl_v ? st_q.pl : st_q.cnt[LO-1:0]};
                st_d.ph_v = 1'b0;
                st_d.pl_v = 1'b0;
            end else if (st_q.mode == MODE_CMP) begin
                st_d.cnt = nxt;
                if (nxt == st_q.rld) begin
                    st_d.irq = 1'b1;
                    if (st_q.oen) st_d.out = !st_q.out;
                end
            end else begin
                if (st_q.cnt == st_q.rld) begin
                    st_d.cnt = GTM_CNT_W'(1);
                    st_d.irq = 1'b1;
                end else begin
                    st_d.cnt = nxt;
                end
            end
        end

        // gate closing in gated mode
        if (st_q.en && st_q.mode == MODE_GATE && gate_fall_w) begin
            st_d.irq = 1'b1;
        end

        // register writes
        if (wr_en) begin
            case (gtm_addr_e'(wr_addr))
                A_CTRL: begin
                    st_d.en   = wr_data[CB_EN];
                    st_d.mode = gtm_mode_e'(wr_data[CB_MODE]);
                    st_d.pol  = wr_data[CB_POL];
                    st_d.init = wr_data[CB_INIT];
                    st_d.oen  = wr_data[CB_OEN];
                    st_d.exp  = wr_data[CB_EXP +: GTM_EXP_W];
                    if (!st_q.en) st_d.out = wr_data[CB_INIT];
                end
                A_CNTH: begin
                    if (st_q.en) begin
                        st_d.ph_v = 1'b1;
                        st_d.ph   = wr_data;
                    end else begin
                        st_d.cnt[HI:LO] = wr_data;
                    end
                end
                A_CNTL: begin
                    if (st_q.en) begin
                        st_d.pl_v = 1'b1;
                        st_d.pl   = wr_data;
                    end else begin
                        st_d.cnt[LO-1:0] = wr_data;
                    end
                end
                A_RLDH:  st_d.rld[HI:LO]   = wr_data;
                A_RLDL:  st_d.rld[LO-1:0]  = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_out = st_q.out;
    assign irq     = st_q.irq;
endmodule

// File: rtl/gtm_timer_chk.sv
module gtm_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        gated,
    input logic        tick,
    input logic        gate_act,
    input logic        pend,
    input logic [15:0] cnt,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic        tmr_out,
    input logic        irq
);
    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !irq); // R10

    AST_OUT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!en) && !$past(wr_en && wr_addr == 3'd0)) |-> $stable(tmr_out)); // R5

    AST_TOGGLE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (tmr_out != $past(tmr_out))) |-> irq); // R4

    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && gated && !gate_act) |-> $stable(cnt)); // R7

    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && !gated && tick && !pend && cnt == 16'hFFFF) |-> (cnt == 16'h0000)); // R3

    AST_CMP_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && !gated && tick && !pend) |-> (cnt == 16'($past(cnt) + 16'd1))); // R2
endmodule

bind gtm_timer gtm_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (st_q.en),
    .gated   (st_q.mode),
    .tick    (tick_w),
    .gate_act(gate_act_w),
    .pend    (pend_w),
    .cnt     (st_q.cnt),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .tmr_out (tmr_out),
    .irq     (irq)
);

// File: tb/gtm_timer_test.sv
`timescale 1ns/1ps
module gtm_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tmr_in = 1'b0;
    logic       tmr_out;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gtm_timer uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .tmr_in (tmr_in),
        .tmr_out(tmr_out),
        .irq    (irq)
    );

    function automatic logic [7:0] ctl(input bit en, input bit gated, input bit pol,
                                       input bit init, input bit oen, input int e);
        return {3'(e), oen, init, pol, gated, en};
    endfunction

    function automatic int cmp_wait(input int s, input int c, input int e);
        return (((c - s) % 65536 + 65536) % 65536) << e;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at a negedge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq(output int n, input int lim);
        n = 0;
        do begin
            @(posedge clk); @(negedge clk);
            n++;
        end while (!irq && n < lim);
    endtask

    task automatic quiet(input int cyc, output int seen);
        seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk); @(negedge clk);
            if (irq) seen++;
        end
    endtask

    task automatic load(input logic [7:0] c, input int s, input int r);
        wr(3'd0, c);
        wr(3'd1, 8'(s >> 8)); wr(3'd2, 8'(s));
        wr(3'd3, 8'(r >> 8)); wr(3'd4, 8'(r));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, seen, s, c, e;
        void'($urandom(32'd7301));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R1 out", int'(tmr_out), 0);
        chk("R1 irq", int'(irq), 0);

        // R5 initial level while disabled
        wr(3'd0, ctl(0, 0, 0, 1, 1, 0));
        chk("R5 init load", int'(tmr_out), 1);
        quiet(5, seen);
        chk("R5 hold", int'(tmr_out), 1);
        chk("R10 no irq idle", seen, 0);

        // R2/R4 compare with toggle
        load(ctl(0, 0, 0, 1, 1, 0), 0, 4);
        wr(3'd0, ctl(1, 0, 0, 1, 1, 0));
        wait_irq(n, 1000);
        chk("R2 first match", n, 4);
        chk("R4 toggle low", int'(tmr_out), 0);
        @(posedge clk); @(negedge clk);
        chk("R10 pulse width", int'(irq), 0);
        wr(3'd4, 8'd8);
        wait_irq(n, 1000);
        chk("R2 no reset after match", n, 2);
        chk("R4 toggle high", int'(tmr_out), 1);

        // disable: out kept; rewrite while disabled loads init
        wr(3'd0, ctl(0, 0, 0, 0, 0, 0));
        chk("R5 kept on disable", int'(tmr_out), 1);
        wr(3'd0, ctl(0, 0, 0, 0, 0, 0));
        chk("R5 reload init", int'(tmr_out), 0);

        // R4 no toggle when output function off
        load(ctl(0, 0, 0, 0, 0, 1), 16'h10, 16'h13);
        wr(3'd0, ctl(1, 0, 0, 0, 0, 1));
        wait_irq(n, 1000);
        chk("R4/R6 match div2", n, 6);
        chk("R4 no toggle", int'(tmr_out), 0);

        // R3 wrap
        load(ctl(0, 0, 0, 0, 0, 1), 16'hFFF0, 16'h0005);
        wr(3'd0, ctl(1, 0, 0, 0, 0, 1));
        wait_irq(n, 1000);
        chk("R3 wrap", n, cmp_wait(16'hFFF0, 5, 1));

        // R6 max ratio
        load(ctl(0, 0, 0, 0, 0, 7), 100, 103);
        wr(3'd0, ctl(1, 0, 0, 0, 0, 7));
        wait_irq(n, 2000);
        chk("R6 div128", n, 384);

        // R6 prescaler cleared by disable
        load(ctl(0, 0, 0, 0, 0, 2), 0, 5);
        wr(3'd0, ctl(1, 0, 0, 0, 0, 2));
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr(3'd0, ctl(0, 0, 0, 0, 0, 2));
        wr(3'd0, ctl(1, 0, 0, 0, 0, 2));
        wait_irq(n, 1000);
        chk("R6 presc clear", n, 20);

        // random compare intervals
        for (int k = 0; k < 8; k++) begin
            e = int'($urandom % 4);
            s = int'($urandom % 65536);
            c = (s + 1 + int'($urandom % 150)) % 65536;
            load(ctl(0, 0, 0, 0, 0, e), s, c);
            wr(3'd0, ctl(1, 0, 0, 0, 0, e));
            wait_irq(n, 5000);
            chk("R2/R6 random interval", n, cmp_wait(s, c, e));
        end

        // R9 count byte written while running
        load(ctl(0, 0, 0, 0, 0, 0), 0, 16'h0100);
        wr(3'd0, ctl(1, 0, 0, 0, 0, 0));
        wr(3'd1, 8'h00);
        wr(3'd2, 8'hF0);
        wait_irq(n, 1000);
        chk("R9 live load", n, 17);

        // R7/R8 gated, active high
        wr(3'd0, ctl(0, 1, 1, 0, 0, 0));
        tmr_in = 1'b1;
        load(ctl(0, 1, 1, 0, 0, 0), 0, 20);
        wr(3'd0, ctl(1, 1, 1, 0, 0, 0));
        wait_irq(n, 1000);
        chk("R7 first reload", n, 21);
        wait_irq(n, 1000);
        chk("R7 restart at one", n, 20);
        quiet(5, seen);
        chk("R10 gated quiet", seen, 0);
        tmr_in = 1'b0;
        wait_irq(n, 100);
        chk("R8 deassert irq", n, 3);
        quiet(10, seen);
        chk("R7 frozen no irq", seen, 0);
        tmr_in = 1'b1;
        wait_irq(n, 1000);
        chk("R7 resume count", n, 15);
        @(posedge clk); @(negedge clk);
        chk("R10 gated pulse width", int'(irq), 0);

        // R7/R8 active low
        wr(3'd0, ctl(0, 1, 0, 0, 0, 0));
        tmr_in = 1'b0;
        load(ctl(0, 1, 0, 0, 0, 0), 0, 5);
        quiet(4, seen);
        chk("R10 disabled gate edge", seen, 0);
        wr(3'd0, ctl(1, 1, 0, 0, 0, 0));
        wait_irq(n, 1000);
        chk("R7 low active reload", n, 6);
        @(posedge clk); @(negedge clk);
        tmr_in = 1'b1;
        wait_irq(n, 100);
        chk("R8 low active deassert", n, 3);

        // R10 disabled gate toggling
        wr(3'd0, ctl(0, 1, 0, 0, 0, 0));
        tmr_in = 1'b0;
        quiet(4, seen);
        tmr_in = 1'b1;
        quiet(6, seen);
        chk("R10 disabled no irq", seen, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule